// File: doc/BRIEF.md
# Tower-Pair Hamming Link Framer

The framer packs two 9-bit calorimeter tower words into a 24-bit link frame once per bunch crossing. Five Hamming check bits cover the 18 tower bits, and a single flag bit tells the receiver whether the frame holds trigger data or a synchronisation pattern. The frame goes out as three bytes on a bus clocked at three times the crossing rate, ready for an 8b/10b serialiser. A frame-start marker accompanies the first byte of each crossing.

The design runs entirely on the byte clock. A one-cycle crossing strobe, asserted once every three byte cycles, marks the cycle in which the tower words and the flag are valid. A receive-side deframer and Hamming corrector sit in the same block for loopback self-test. It collects three bytes after a start marker, recomputes the syndrome, repairs a single flipped tower bit and reports what it found.

Top module: `hlf_framer`

## Requirements
- R1: While rst_ni is low, byte_o, sof_o and rx_valid_o are all 0.
- R2: The frame places tower_a_i in bits [8:0], tower_b_i in bits [17:9], the check field in bits [22:18] and sync_flag_i in bit 23.
- R3: In the cycle after an edge that samples xing_stb_i high, byte_o carries frame bits [7:0] with sof_o high. The next two cycles carry bits [15:8] and then [23:16], with sof_o low.
- R4: The data bits d[17:0] = {tower_b, tower_a} are assigned in increasing order to the positions 1..23 that are not powers of two (d0 at position 3, d1 at 5, ..., d17 at 23). Check bit j is the XOR of the data bits whose position has bit j set.
- R5: Once the third byte has been sent, if no new strobe has come, byte_o is 0 and sof_o is 0.
- R6: A strobe that arrives while a frame is still being sent drops the rest of that frame. The next cycle carries byte 0 of the new frame with sof_o high.
- R7: Three rx bytes that start with rx_sof_i high, with no further rx_sof_i, give a one-cycle rx_valid_o pulse in the cycle after the third byte. On an error-free frame, the towers and the flag equal the sent values, and rx_err_o and rx_fix_o are 0.
- R8: A single flipped bit among frame bits [17:0] is corrected in rx_tower_a_o and rx_tower_b_o, with rx_err_o = 1 and rx_fix_o = 1.
- R9: A single flipped bit among frame bits [22:18] leaves the towers as sent, with rx_err_o = 1 and rx_fix_o = 0.
- R10: Rx bytes that do not follow an rx_sof_i produce no rx_valid_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock, three times the crossing rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| xing_stb_i | input | 1 | Crossing strobe; the tower words are valid in this cycle |
| tower_a_i | input | 9 | First tower word |
| tower_b_i | input | 9 | Second tower word |
| sync_flag_i | input | 1 | 1 = synchronisation pattern, 0 = trigger data |
| byte_o | output | 8 | Outgoing link byte |
| sof_o | output | 1 | High with the first byte of a frame |
| rx_byte_i | input | 8 | Incoming link byte for the self-test decoder |
| rx_sof_i | input | 1 | Frame start for the incoming byte |
| rx_valid_o | output | 1 | One-cycle pulse when a decoded frame is presented |
| rx_tower_a_o | output | 9 | Decoded, corrected first tower |
| rx_tower_b_o | output | 9 | Decoded, corrected second tower |
| rx_sync_flag_o | output | 1 | Decoded flag bit |
| rx_err_o | output | 1 | Syndrome was non-zero |
| rx_fix_o | output | 1 | A tower bit was flipped back |

## Verification
The bench feeds the framer's own bytes back into the decoder and flips single bits at chosen frame positions. Flips at bits 8/9 (the boundary between the towers) and at 17/18 (the boundary between data and check bits) catch an off-by-one in the position map: a wrong map would repair the wrong tower bit or report a check-bit error as a data repair. A second strobe one cycle after the first exposes a serialiser that finishes the old frame before starting the new one. A stream with its start marker removed exposes a decoder that latches onto unframed bytes.

// File: rtl/hlf_pkg.sv
package hlf_pkg;
  localparam int unsigned TOWER_W = 9;
  localparam int unsigned CHK_W   = 5;
  localparam int unsigned BYTE_W  = 8;

  // Hamming position of data bit k: k-th non-power-of-two in 1..2**chk_w-1
  function automatic int unsigned data_pos(input int unsigned k, input int unsigned chk_w);
    int unsigned n;
    data_pos = 0;
    n = 0;
    for (int unsigned p = 1; p < (32'd1 << chk_w); p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == k) data_pos = p;
        n++;
      end
    end
  endfunction
endpackage

// File: rtl/hlf_ham_gen.sv
module hlf_ham_gen
  import hlf_pkg::*;
#(
  parameter int unsigned DATA_W = 2 * TOWER_W,
  parameter int unsigned CW     = CHK_W
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CW-1:0]     chk_o
);
  logic [DATA_W-1:0] sel [CW];

  for (genvar j = 0; j < CW; j++) begin : g_bit
    for (genvar k = 0; k < DATA_W; k++) begin : g_sel
      localparam int unsigned POS = data_pos(k, CW);
      assign sel[j][k] = ((POS >> j) & 1) != 0 ? data_i[k] : 1'b0;
    end
    assign chk_o[j] = ^sel[j];
  end
endmodule

// File: rtl/hlf_ham_fix.sv
module hlf_ham_fix
  import hlf_pkg::*;
#(
  parameter int unsigned DATA_W = 2 * TOWER_W,
  parameter int unsigned CW     = CHK_W
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [CW-1:0]     chk_i,
  output logic [DATA_W-1:0] data_o,
  output logic              err_o,
  output logic              fix_o
);
  logic [CW-1:0]     chk_calc;
  logic [CW-1:0]     syn;
  logic [DATA_W-1:0] hit;

  hlf_ham_gen #(.DATA_W(DATA_W), .CW(CW)) u_gen (
    .data_i (data_i),
    .chk_o  (chk_calc)
  );

  assign syn = chk_calc ^ chk_i;

  for (genvar k = 0; k < DATA_W; k++) begin : g_fix
    localparam int unsigned POS = data_pos(k, CW);
    assign hit[k]    = (syn == CW'(POS));
    assign data_o[k] = data_i[k] ^ hit[k];
  end

  assign err_o = |syn;
  assign fix_o = |hit;
endmodule

// File: rtl/hlf_tx_mux.sv
module hlf_tx_mux #(
  parameter int unsigned FRAME_W = 24,
  parameter int unsigned BYTE_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [BYTE_W-1:0]  byte_o,
  output logic               sof_o
);
  localparam int unsigned NBYTES = FRAME_W / BYTE_W;
  localparam int unsigned REST_W = FRAME_W - BYTE_W;
  localparam int unsigned CNT_W  = $clog2(NBYTES);

  logic [REST_W-1:0] rest_q;
  logic [CNT_W-1:0]  left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_o <= '0;
      sof_o  <= 1'b0;
      rest_q <= '0;
      left_q <= '0;
    end else if (load_i) begin
      byte_o <= frame_i[BYTE_W-1:0];
      sof_o  <= 1'b1;
      rest_q <= frame_i[FRAME_W-1:BYTE_W];
      left_q <= CNT_W'(NBYTES - 1);
    end else if (left_q != '0) begin
      byte_o <= rest_q[BYTE_W-1:0];
      sof_o  <= 1'b0;
      rest_q <= rest_q >> BYTE_W;
      left_q <= left_q - 1'b1;
    end else begin
      byte_o <= '0;
      sof_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/hlf_rx_collect.sv
module hlf_rx_collect #(
  parameter int unsigned FRAME_W = 24,
  parameter int unsigned BYTE_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [BYTE_W-1:0]  byte_i,
  input  logic               sof_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               done_o
);
  localparam int unsigned NBYTES = FRAME_W / BYTE_W;
  localparam int unsigned HOLD_W = FRAME_W - BYTE_W;
  localparam int unsigned IDX_W  = $clog2(NBYTES);

  logic [HOLD_W-1:0] hold_q;
  logic [IDX_W-1:0]  idx_q;   // 0 = idle, else index of next expected byte

  assign done_o  = !sof_i && (idx_q == IDX_W'(NBYTES - 1));
  assign frame_o = {byte_i, hold_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      idx_q  <= '0;
    end else if (sof_i) begin
      hold_q[BYTE_W-1:0] <= byte_i;
      idx_q              <= IDX_W'(1);
    end else if (done_o) begin
      idx_q <= '0;
    end else if (idx_q != '0) begin
      hold_q[idx_q*BYTE_W +: BYTE_W] <= byte_i;
      idx_q                          <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/hlf_framer.sv
module hlf_framer
  import hlf_pkg::*;
#(
  parameter int unsigned TW = TOWER_W,
  parameter int unsigned CW = CHK_W,
  parameter int unsigned BW = BYTE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          xing_stb_i,
  input  logic [TW-1:0] tower_a_i,
  input  logic [TW-1:0] tower_b_i,
  input  logic          sync_flag_i,
  output logic [BW-1:0] byte_o,
  output logic          sof_o,
  input  logic [BW-1:0] rx_byte_i,
  input  logic          rx_sof_i,
  output logic          rx_valid_o,
  output logic [TW-1:0] rx_tower_a_o,
  output logic [TW-1:0] rx_tower_b_o,
  output logic          rx_sync_flag_o,
  output logic          rx_err_o,
  output logic          rx_fix_o
);
  localparam int unsigned DATA_W  = 2 * TW;
  localparam int unsigned FRAME_W = DATA_W + CW + 1;

  logic [DATA_W-1:0]  tx_data;
  logic [CW-1:0]      tx_chk;
  logic [FRAME_W-1:0] tx_frame;

  assign tx_data  = {tower_b_i, tower_a_i};
  assign tx_frame = {sync_flag_i, tx_chk, tx_data};

  hlf_ham_gen #(.DATA_W(DATA_W), .CW(CW)) u_tx_ham (
    .data_i (tx_data),
    .chk_o  (tx_chk)
  );

  hlf_tx_mux #(.FRAME_W(FRAME_W), .BYTE_W(BW)) u_tx_mux (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (xing_stb_i),
    .frame_i (tx_frame),
    .byte_o  (byte_o),
    .sof_o   (sof_o)
  );

  logic [FRAME_W-1:0] rx_frame;
  logic               rx_done;
  logic [DATA_W-1:0]  rx_data;
  logic               rx_err;
  logic               rx_fix;

  hlf_rx_collect #(.FRAME_W(FRAME_W), .BYTE_W(BW)) u_rx_col (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .byte_i  (rx_byte_i),
    .sof_i   (rx_sof_i),
    .frame_o (rx_frame),
    .done_o  (rx_done)
  );

  hlf_ham_fix #(.DATA_W(DATA_W), .CW(CW)) u_rx_fix (
    .data_i (rx_frame[DATA_W-1:0]),
    .chk_i  (rx_frame[DATA_W +: CW]),
    .data_o (rx_data),
    .err_o  (rx_err),
    .fix_o  (rx_fix)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_valid_o     <= 1'b0;
      rx_tower_a_o   <= '0;
      rx_tower_b_o   <= '0;
      rx_sync_flag_o <= 1'b0;
      rx_err_o       <= 1'b0;
      rx_fix_o       <= 1'b0;
    end else begin
      rx_valid_o <= rx_done;
      if (rx_done) begin
        rx_tower_a_o   <= rx_data[TW-1:0];
        rx_tower_b_o   <= rx_data[DATA_W-1:TW];
        rx_sync_flag_o <= rx_frame[FRAME_W-1];
        rx_err_o       <= rx_err;
        rx_fix_o       <= rx_fix;
      end
    end
  end
endmodule

// File: rtl/hlf_framer_chk.sv
module hlf_framer_chk #(
  parameter int unsigned BW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          xing_stb_i,
  input logic [BW-1:0] byte_o,
  input logic          sof_o,
  input logic          rx_sof_i,
  input logic          rx_valid_o,
  input logic          rx_err_o,
  input logic          rx_fix_o
);
  p_sof_after_stb_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xing_stb_i |=> sof_o);

  p_idle_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xing_stb_i && !$past(xing_stb_i) && !$past(xing_stb_i, 2)) |=> (byte_o == '0 && !sof_o));

  p_valid_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  p_fix_has_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && rx_fix_o) |-> rx_err_o);

  p_valid_needs_sof_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> ($past(rx_sof_i, 3) && !$past(rx_sof_i, 2) && !$past(rx_sof_i, 1)));
endmodule

bind hlf_framer hlf_framer_chk #(.BW(BW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .xing_stb_i (xing_stb_i),
  .byte_o     (byte_o),
  .sof_o      (sof_o),
  .rx_sof_i   (rx_sof_i),
  .rx_valid_o (rx_valid_o),
  .rx_err_o   (rx_err_o),
  .rx_fix_o   (rx_fix_o)
);

// File: tb/hlf_framer_bench.sv
module hlf_framer_bench;
  typedef struct packed {
    logic [8:0] ta;
    logic [8:0] tb;
    logic       fl;
    logic [4:0] flip;   // frame bit to corrupt, 31 = none
    logic       err;
    logic       fix;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    {9'h000, 9'h000, 1'b0, 5'd31, 1'b0, 1'b0},
    {9'h1FF, 9'h1FF, 1'b1, 5'd31, 1'b0, 1'b0},
    {9'h0A5, 9'h15A, 1'b0, 5'd3,  1'b1, 1'b1},
    {9'h123, 9'h0C4, 1'b1, 5'd17, 1'b1, 1'b1},
    {9'h07F, 9'h100, 1'b0, 5'd18, 1'b1, 1'b0},
    {9'h155, 9'h0AA, 1'b1, 5'd22, 1'b1, 1'b0},
    {9'h001, 9'h100, 1'b0, 5'd8,  1'b1, 1'b1},
    {9'h1E0, 9'h01F, 1'b0, 5'd9,  1'b1, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stb = 1'b0;
  logic [8:0] ta = '0, tb = '0;
  logic       fl = 1'b0;
  logic [7:0] inj = '0;
  logic       kill = 1'b0;
  logic [7:0] byte_w;
  logic       sof_w;
  logic       rx_valid, rx_fl, rx_err, rx_fix;
  logic [8:0] rx_ta, rx_tb;
  int         n_chk = 0;
  int         n_err = 0;

  always #4 clk = ~clk;

  hlf_framer u_hlf_framer (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .xing_stb_i     (stb),
    .tower_a_i      (ta),
    .tower_b_i      (tb),
    .sync_flag_i    (fl),
    .byte_o         (byte_w),
    .sof_o          (sof_w),
    .rx_byte_i      (byte_w ^ inj),
    .rx_sof_i       (sof_w & ~kill),
    .rx_valid_o     (rx_valid),
    .rx_tower_a_o   (rx_ta),
    .rx_tower_b_o   (rx_tb),
    .rx_sync_flag_o (rx_fl),
    .rx_err_o       (rx_err),
    .rx_fix_o       (rx_fix)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] ref_chk(input logic [17:0] d);
    logic [4:0] c = '0;
    int k = 0;
    for (int p = 1; p < 24; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (d[k]) c ^= p[4:0];
        k++;
      end
    end
    return c;
  endfunction

  function automatic logic [23:0] ref_frame(input logic [8:0] a, input logic [8:0] b, input logic f);
    return {f, ref_chk({b, a}), b, a};
  endfunction

  task automatic run_vec(input vec_t v, input bit no_sof);
    logic [23:0] fr = ref_frame(v.ta, v.tb, v.fl);
    logic [23:0] m  = (v.flip < 5'd23) ? (24'd1 << v.flip) : 24'd0;
    @(negedge clk);
    ta = v.ta; tb = v.tb; fl = v.fl; stb = 1'b1; kill = no_sof;
    @(negedge clk);
    stb = 1'b0; ta = ~v.ta; tb = ~v.tb; fl = ~v.fl;
    check(byte_w == fr[7:0], "R3 byte0", {24'd0, byte_w}, {24'd0, fr[7:0]});
    check(sof_w == 1'b1, "R3 sof", {31'd0, sof_w}, 32'd1);
    inj = m[7:0];
    @(negedge clk);
    check(byte_w == fr[15:8] && !sof_w, "R2 byte1", {23'd0, sof_w, byte_w}, {24'd0, fr[15:8]});
    inj = m[15:8];
    @(negedge clk);
    check(byte_w == fr[23:16] && !sof_w, "R4 byte2 check field", {23'd0, sof_w, byte_w}, {24'd0, fr[23:16]});
    inj = m[23:16];
    @(negedge clk);
    inj = '0;
    check(byte_w == 8'd0 && !sof_w, "R5 idle", {23'd0, sof_w, byte_w}, 32'd0);
    if (no_sof) begin
      check(!rx_valid, "R10 no valid", {31'd0, rx_valid}, 32'd0);
      @(negedge clk);
      check(!rx_valid, "R10 no valid late", {31'd0, rx_valid}, 32'd0);
    end else begin
      check(rx_valid, "R7 valid", {31'd0, rx_valid}, 32'd1);
      check(rx_ta == v.ta && rx_tb == v.tb && rx_fl == v.fl,
            !v.err ? "R7 data" : (v.fix ? "R8 data" : "R9 data"),
            {13'd0, rx_fl, rx_tb, rx_ta}, {13'd0, v.fl, v.tb, v.ta});
      check(rx_err == v.err && rx_fix == v.fix,
            !v.err ? "R7 flags" : (v.fix ? "R8 flags" : "R9 flags"),
            {30'd0, rx_err, rx_fix}, {30'd0, v.err, v.fix});
      @(negedge clk);
      check(!rx_valid, "R7 single pulse", {31'd0, rx_valid}, 32'd0);
    end
    kill = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    n_err++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [23:0] fa, fb;
    repeat (3) @(negedge clk);
    check(byte_w == 8'd0 && !sof_w && !rx_valid, "R1 reset",
          {22'd0, rx_valid, sof_w, byte_w}, 32'd0);
    stb = 1'b1;
    @(negedge clk);
    check(byte_w == 8'd0 && !sof_w, "R1 reset holds with strobe", {23'd0, sof_w, byte_w}, 32'd0);
    stb = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], 1'b0);

    // R10: stream with start marker removed
    run_vec(VEC[1], 1'b1);

    // R6: restart mid-frame
    fa = ref_frame(9'h0F0, 9'h10F, 1'b0);
    fb = ref_frame(9'h033, 9'h1CC, 1'b1);
    @(negedge clk);
    ta = 9'h0F0; tb = 9'h10F; fl = 1'b0; stb = 1'b1;
    @(negedge clk);
    check(byte_w == fa[7:0] && sof_w, "R6 first frame byte0", {23'd0, sof_w, byte_w}, {23'd0, 1'b1, fa[7:0]});
    ta = 9'h033; tb = 9'h1CC; fl = 1'b1;
    @(negedge clk);
    stb = 1'b0;
    check(byte_w == fb[7:0] && sof_w, "R6 restart byte0", {23'd0, sof_w, byte_w}, {23'd0, 1'b1, fb[7:0]});
    @(negedge clk);
    check(byte_w == fb[15:8] && !sof_w, "R6 restart byte1", {23'd0, sof_w, byte_w}, {24'd0, fb[15:8]});
    @(negedge clk);
    check(byte_w == fb[23:16] && !sof_w, "R6 restart byte2", {23'd0, sof_w, byte_w}, {24'd0, fb[23:16]});
    @(negedge clk);
    check(rx_valid && rx_ta == 9'h033 && rx_tb == 9'h1CC && rx_fl,
          "R6 decoder follows restart", {12'd0, rx_valid, rx_fl, rx_tb, rx_ta},
          {12'd0, 1'b1, 1'b1, 9'h1CC, 9'h033});
    check(byte_w == 8'd0, "R5 idle after restart", {24'd0, byte_w}, 32'd0);

    // R1: asynchronous reset mid-frame
    @(negedge clk);
    stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
    rst_n = 1'b0;
    #1;
    check(byte_w == 8'd0 && !sof_w && !rx_valid, "R1 async reset",
          {22'd0, rx_valid, sof_w, byte_w}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule